// File: doc/BRIEF.md
# SPI Slave Transaction Framer

This block is the framing stage on the receive side of an SPI slave. It watches a chip-select input that has already been brought into the system clock domain, and it counts the one-cycle strobes that mark each sampled data bit. From these it decides where a transaction starts and where it ends. When a transaction ends it raises a sticky interrupt flag. It also records whether exactly the programmed number of bits arrived.

Software programs four configuration inputs: the active polarity of the select, the trigger interpretation, a word length and a word count. In edge interpretation, a transaction runs from an activating transition of the select to the next deactivating one, and only that deactivating transition closes it. In level interpretation, the transaction closes as soon as the programmed bit total has arrived, or earlier if the select drops first. The completeness flag tells these two outcomes apart.

Top module: `spi_slv_frame`

## Requirements
- R1: After reset, `irq_o` and `done_full_o` are both 0.
- R2: With `cfg_act_high_i`=1 the select is active when `sel_i`=1; with `cfg_act_high_i`=0 it is active when `sel_i`=0. While the select is inactive, bit strobes start nothing and set no flag.
- R3: Edge interpretation (`cfg_level_i`=0): the first cycle in which the select is seen inactive after being active ends the transaction. `irq_o` is 1 from the following cycle. `done_full_o` becomes 1 if the bit count equals the target exactly, and 0 if it is above or below the target.
- R4: Edge interpretation: as long as the select stays active, `irq_o` is never set, however many bits arrive, including more than the target.
- R5: Level interpretation (`cfg_level_i`=1): if the select goes inactive before the target is reached, the transaction ends, `irq_o` is set in the following cycle and `done_full_o` becomes 0.
- R6: Level interpretation: the strobe that brings the count to the target sets `irq_o` and `done_full_o` to 1 in the following cycle. Later strobes in the same selection are ignored. The deassertion that follows raises no new interrupt and leaves `done_full_o` at 1.
- R7: Target = word bits × words. Word bits is `cfg_wlen_i` (5 bits), where value 0 means 32 bits. Words is `cfg_words_i`+1 (1 bit), so 0 means one word and 1 means two words.
- R8: `irq_o` stays at 1 until a cycle with `irq_clr_i`=1 clears it. If a set and a clear occur in the same cycle, the set wins.
- R9: The bit count restarts at every activating transition of the select. A strobe in the cycle of that transition counts as the first bit.
- R10: `done_full_o` is rewritten at the end of every transaction and holds its value between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Select, already synchronized |
| bit_stb_i | input | 1 | One-cycle pulse per sampled data bit |
| cfg_act_high_i | input | 1 | 1: select active high, 0: active low |
| cfg_level_i | input | 1 | 1: level interpretation, 0: edge interpretation |
| cfg_wlen_i | input | 5 | Bits per word, 0 means 32 |
| cfg_words_i | input | 1 | Words per transaction minus one |
| irq_clr_i | input | 1 | Write-one clear of the interrupt flag |
| irq_o | output | 1 | Sticky transaction-end interrupt |
| done_full_o | output | 1 | Last transaction carried exactly the target bit count |

## Verification
The assertions assume that the configuration inputs stay constant while the select is active. They also assume that a change of polarity never produces a spurious transition on its own. The bench writes configuration only while the select is inactive. When it changes polarity, it updates `sel_i` in the same cycle, so that the select is still seen as inactive. It drives strobes as single-cycle pulses, matching what an upstream edge synchronizer produces.

// File: rtl/spi_slv_frame_pkg.sv
package spi_slv_frame_pkg;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_ACTIVE = 2'd1,
        FR_HOLD   = 2'd2
    } fr_state_e;

endpackage

// File: rtl/spi_slv_sel_edge.sv
module spi_slv_sel_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic act_high_i,
    output logic act_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } sel_regs_t;

    sel_regs_t cur_q, nxt_d;
    logic      act_now;

    always_comb begin
        act_now   = act_high_i ? sel_i : ~sel_i;
        nxt_d     = cur_q;
        nxt_d.prev = act_now;
        act_o     = act_now;
        rise_o    = act_now & ~cur_q.prev;
        fall_o    = ~act_now & cur_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o) else $error("rise held"); // R9

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o) else $error("fall held"); // R3

endmodule

// File: rtl/spi_slv_bit_tally.sv
module spi_slv_bit_tally #(
    parameter int WLEN_W = 5,
    parameter int WCNT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              cnt_en_i,
    input  logic              bit_stb_i,
    input  logic [WLEN_W-1:0] cfg_wlen_i,
    input  logic [WCNT_W-1:0] cfg_words_i,
    output logic              hit_o,
    output logic              full_o
);

    localparam int MAX_BITS = (2 ** WLEN_W) * (2 ** WCNT_W);
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_regs_t;

    tally_regs_t      cur_q, nxt_d;
    logic [CNT_W-1:0] word_bits;
    logic [CNT_W-1:0] target;
    logic             take;

    always_comb begin
        word_bits = (cfg_wlen_i == '0) ? CNT_W'(2 ** WLEN_W) : CNT_W'(cfg_wlen_i);
        target    = CNT_W'(int'(word_bits) * (int'(cfg_words_i) + 1));
        take      = cnt_en_i & bit_stb_i;
        nxt_d     = cur_q;
        if (restart_i) begin
            nxt_d.cnt = take ? CNT_W'(1) : '0;
        end else if (take && cur_q.cnt != CNT_MAX) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
        hit_o  = take && (nxt_d.cnt == target);
        full_o = (cur_q.cnt == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cur_q.cnt <= CNT_W'(1)) else $error("count not restarted"); // R9

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> (cur_q.cnt == $past(cur_q.cnt)) ||
                       (cur_q.cnt == $past(cur_q.cnt) + CNT_W'(1)))
        else $error("count jumped"); // R9

endmodule

// File: rtl/spi_slv_frame_ctl.sv
module spi_slv_frame_ctl
    import spi_slv_frame_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic level_i,
    input  logic hit_i,
    input  logic full_i,
    input  logic irq_clr_i,
    output logic cnt_en_o,
    output logic irq_o,
    output logic done_full_o
);

    typedef struct packed {
        fr_state_e st;
        logic      irq;
        logic      full;
    } ctl_regs_t;

    ctl_regs_t cur_q, nxt_d;
    logic      irq_set;
    logic      in_xfer;

    always_comb begin
        nxt_d    = cur_q;
        irq_set  = 1'b0;
        in_xfer  = rise_i || (cur_q.st == FR_ACTIVE);
        cnt_en_o = rise_i || (cur_q.st == FR_ACTIVE && act_i);
        if (fall_i && cur_q.st == FR_ACTIVE) begin
            irq_set    = 1'b1;
            nxt_d.full = full_i;
            nxt_d.st   = FR_IDLE;
        end else if (fall_i && cur_q.st == FR_HOLD) begin
            nxt_d.full = 1'b1;
            nxt_d.st   = FR_IDLE;
        end else if (in_xfer) begin
            nxt_d.st = FR_ACTIVE;
            if (level_i && hit_i) begin
                irq_set    = 1'b1;
                nxt_d.full = 1'b1;
                nxt_d.st   = FR_HOLD;
            end
        end
        if (irq_set)        nxt_d.irq = 1'b1;
        else if (irq_clr_i) nxt_d.irq = 1'b0;
        irq_o       = cur_q.irq;
        done_full_o = cur_q.full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: FR_IDLE, irq: 1'b0, full: 1'b0};
        else        cur_q <= nxt_d;
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.irq && !irq_clr_i) |=> cur_q.irq) else $error("irq dropped"); // R8

    AST_EDGE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_i && !fall_i && !cur_q.irq) |=> !cur_q.irq) else $error("edge irq w/o fall"); // R4

    AST_LEVEL_HIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && in_xfer && !fall_i && hit_i) |=> (cur_q.irq && cur_q.full))
        else $error("level hit missed"); // R6

    AST_FALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && cur_q.st == FR_ACTIVE) |=> cur_q.irq) else $error("fall missed"); // R5

    AST_HOLD_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == FR_HOLD) |=> cur_q.full) else $error("full lost in hold"); // R6

endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame #(
    parameter int WLEN_W = 5,
    parameter int WCNT_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              bit_stb_i,
    input  logic              cfg_act_high_i,
    input  logic              cfg_level_i,
    input  logic [WLEN_W-1:0] cfg_wlen_i,
    input  logic [WCNT_W-1:0] cfg_words_i,
    input  logic              irq_clr_i,
    output logic              irq_o,
    output logic              done_full_o
);

    logic act, rise, fall;
    logic cnt_en, hit, full;

    spi_slv_sel_edge u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .act_high_i (cfg_act_high_i),
        .act_o      (act),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    spi_slv_bit_tally #(
        .WLEN_W (WLEN_W),
        .WCNT_W (WCNT_W)
    ) u_tally (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (rise),
        .cnt_en_i    (cnt_en),
        .bit_stb_i   (bit_stb_i),
        .cfg_wlen_i  (cfg_wlen_i),
        .cfg_words_i (cfg_words_i),
        .hit_o       (hit),
        .full_o      (full)
    );

    spi_slv_frame_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .rise_i      (rise),
        .fall_i      (fall),
        .level_i     (cfg_level_i),
        .hit_i       (hit),
        .full_i      (full),
        .irq_clr_i   (irq_clr_i),
        .cnt_en_o    (cnt_en),
        .irq_o       (irq_o),
        .done_full_o (done_full_o)
    );

    AST_IDLE_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !fall && !irq_o && !irq_clr_i) |=> !irq_o) else $error("irq while inactive"); // R2

endmodule

// File: tb/spi_slv_frame_test.sv
`timescale 1ns/1ps
module spi_slv_frame_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_i = 1'b0;
    logic       bit_stb_i = 1'b0;
    logic       cfg_act_high_i = 1'b1;
    logic       cfg_level_i = 1'b1;
    logic [4:0] cfg_wlen_i = 5'd4;
    logic [0:0] cfg_words_i = 1'b0;
    logic       irq_clr_i = 1'b0;
    logic       irq_o, done_full_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_slv_frame uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .bit_stb_i(bit_stb_i),
        .cfg_act_high_i(cfg_act_high_i), .cfg_level_i(cfg_level_i),
        .cfg_wlen_i(cfg_wlen_i), .cfg_words_i(cfg_words_i),
        .irq_clr_i(irq_clr_i), .irq_o(irq_o), .done_full_o(done_full_o)
    );

    task automatic chk(input string tag, input logic actual, input logic expect_v);
        checks++;
        if (actual !== expect_v) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, actual, expect_v);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_act(input logic a);
        sel_i = cfg_act_high_i ? a : ~a;
        tick();
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            bit_stb_i = 1'b1; tick();
            bit_stb_i = 1'b0; tick();
        end
    endtask

    task automatic clear_irq();
        irq_clr_i = 1'b1; tick();
        irq_clr_i = 1'b0;
    endtask

    task automatic cfg(input logic hi, input logic lvl, input logic [4:0] wl, input logic w);
        cfg_act_high_i = hi;
        cfg_level_i    = lvl;
        cfg_wlen_i     = wl;
        cfg_words_i    = w;
        sel_i          = hi ? 1'b0 : 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 irq after reset", irq_o, 1'b0);
        chk("R1 done after reset", done_full_o, 1'b0);
    endtask

    task automatic t_level_count();
        cfg(1'b1, 1'b1, 5'd4, 1'b0);
        set_act(1'b1);
        send(3);
        chk("R6 no irq before target", irq_o, 1'b0);
        send(1);
        chk("R6 irq at target", irq_o, 1'b1);
        chk("R6 done at target", done_full_o, 1'b1);
        clear_irq();
        chk("R8 clear", irq_o, 1'b0);
        send(2);
        chk("R6 extra bits ignored", irq_o, 1'b0);
        set_act(1'b0);
        tick();
        chk("R6 deassert no new irq", irq_o, 1'b0);
        chk("R6 done kept", done_full_o, 1'b1);
    endtask

    task automatic t_level_early();
        cfg(1'b0, 1'b1, 5'd4, 1'b1);
        set_act(1'b1);
        chk("R2 low-active level seen", sel_i, 1'b0);
        send(2);
        chk("R7 two words not yet", irq_o, 1'b0);
        set_act(1'b0);
        chk("R5 early end irq", irq_o, 1'b1);
        chk("R5 early end incomplete", done_full_o, 1'b0);
        clear_irq();
    endtask

    task automatic t_inactive_ignored();
        cfg(1'b1, 1'b1, 5'd1, 1'b0);
        send(3);
        chk("R2 strobes while inactive", irq_o, 1'b0);
        cfg(1'b1, 1'b1, 5'd1, 1'b0);
        cfg_act_high_i = 1'b0; sel_i = 1'b1; tick();
        send(2);
        chk("R2 high level inactive when low-active", irq_o, 1'b0);
        set_act(1'b1);
        send(1);
        chk("R2 low-active select counts", irq_o, 1'b1);
        set_act(1'b0);
        clear_irq();
    endtask

    task automatic t_edge();
        cfg(1'b1, 1'b0, 5'd3, 1'b0);
        set_act(1'b1);
        send(3);
        tick(4);
        chk("R4 no irq at target in edge mode", irq_o, 1'b0);
        send(2);
        chk("R4 no irq beyond target", irq_o, 1'b0);
        set_act(1'b0);
        chk("R3 irq on inactive edge", irq_o, 1'b1);
        chk("R3 overshoot incomplete", done_full_o, 1'b0);
        clear_irq();
        set_act(1'b1);
        send(3);
        set_act(1'b0);
        chk("R3 exact irq", irq_o, 1'b1);
        chk("R3 exact complete", done_full_o, 1'b1);
        clear_irq();
        set_act(1'b1);
        send(1);
        chk("R10 held between transactions", done_full_o, 1'b1);
        set_act(1'b0);
        chk("R10 short transaction rewrites", done_full_o, 1'b0);
        clear_irq();
    endtask

    task automatic t_wlen();
        cfg(1'b1, 1'b1, 5'd0, 1'b0);
        set_act(1'b1);
        send(31);
        chk("R7 len0 one word 31", irq_o, 1'b0);
        send(1);
        chk("R7 len0 one word 32", irq_o, 1'b1);
        set_act(1'b0);
        clear_irq();
        cfg(1'b1, 1'b1, 5'd0, 1'b1);
        set_act(1'b1);
        send(63);
        chk("R7 len0 two words 63", irq_o, 1'b0);
        send(1);
        chk("R7 len0 two words 64", irq_o, 1'b1);
        set_act(1'b0);
        clear_irq();
    endtask

    task automatic t_restart_and_priority();
        cfg(1'b1, 1'b1, 5'd4, 1'b0);
        set_act(1'b1);
        send(3);
        set_act(1'b0);
        clear_irq();
        set_act(1'b1);
        send(1);
        chk("R9 count restarted", irq_o, 1'b0);
        send(3);
        chk("R9 full count after restart", irq_o, 1'b1);
        set_act(1'b0);
        cfg(1'b1, 1'b1, 5'd1, 1'b0);
        chk("R8 irq still set", irq_o, 1'b1);
        sel_i = 1'b1; bit_stb_i = 1'b1; irq_clr_i = 1'b1;
        tick();
        bit_stb_i = 1'b0; irq_clr_i = 1'b0;
        chk("R8 set wins over clear", irq_o, 1'b1);
        chk("R9 strobe on start counted", done_full_o, 1'b1);
        clear_irq();
        chk("R8 clear alone", irq_o, 1'b0);
        set_act(1'b0);
    endtask

    initial begin
        tick(2);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_level_count();
        t_level_early();
        t_inactive_ignored();
        t_edge();
        t_wlen();
        t_restart_and_priority();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule